// File: doc/BRIEF.md
# Second-Operand Shift and Extend Unit

This combinational unit prepares the second operand of a 64-bit datapath before it reaches the arithmetic unit. It has two modes. In shift mode a full barrel shifter moves the operand left or right, or rotates it, by up to 63 places. In extend mode the unit takes a byte, halfword or word from the bottom of the operand and widens it with zeros or with its own sign bit. It then applies a small left shift of at most four places.

A size select chooses between a 64-bit and a 32-bit view of the operand. In the 32-bit view only the low half of the operand takes part. The upper half of the result is always zero. Each shift operation also produces a carry-out bit, which the following arithmetic stage can latch into its flags.

Top module: `opc_operand_cond`

## Requirements
- R1: Shift mode (`mode_i`=0) with `sel_i[1:0]`=0 is a logical left shift. Vacated low positions receive zeros.
- R2: Shift mode with `sel_i[1:0]`=1 is a logical right shift. Vacated high positions receive zeros.
- R3: Shift mode with `sel_i[1:0]`=2 is an arithmetic right shift. Vacated high positions receive copies of the operand's top bit (bit 63, or bit 31 in the 32-bit view).
- R4: Shift mode with `sel_i[1:0]`=3 rotates right. Bits leaving the bottom re-enter at the top of the active width.
- R5: For the three shifts, `cout_o` is the last bit pushed out of the operand. For a left shift by n this is bit W-n; for a right shift by n it is bit n-1. W is 64, or 32 in the 32-bit view.
- R6: For rotate right with a nonzero amount, `cout_o` equals the top bit of the result in the active width.
- R7: In shift mode, an effective amount of zero returns the operand unchanged (masked to the active width) and drives `cout_o` to 0.
- R8: In extend mode (`mode_i`=1), `sel_i[2]`=0 zero-extends the field chosen by `sel_i[1:0]`: 0 selects bits 7:0, 1 selects bits 15:0, 2 selects bits 31:0.
- R9: In extend mode with `sel_i[2]`=1, the chosen field is sign-extended from its own top bit.
- R10: In extend mode, the widened value is shifted left by `amt_i[2:0]`. Values 5 to 7 act as 4, and `amt_i[5:3]` is ignored.
- R11: With `wide_i`=0, the shift amount is taken modulo 32, the operation acts on bits 31:0, and `res_o[63:32]` is zero in both modes.
- R12: An extend request for the word field with `wide_i`=0, or one with `sel_i[1:0]`=3, is invalid. It yields `res_o`=0.
- R13: In extend mode, `cout_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 64 | Operand to condition |
| mode_i | input | 1 | 0 selects shift mode, 1 selects extend mode |
| sel_i | input | 3 | Shift: bits 1:0 pick the operation. Extend: bits 1:0 pick the field size, bit 2 picks sign extension |
| amt_i | input | 6 | Shift amount. In extend mode only bits 2:0 are used |
| wide_i | input | 1 | 1 selects the 64-bit view, 0 the 32-bit view |
| res_o | output | 64 | Conditioned operand |
| cout_o | output | 1 | Carry-out of the shift |

## Verification
In a single evaluation, the shift result and the carry-out come from the same staged data. The size select also changes the width, the amount wrap and the upper-half mask at the same time. To provoke these together, the random stimulus sets amount bit 5 while the 32-bit view is active. Directed cases place a one exactly at bit 31 or bit 63, so that an amount wrap and a carry bit position meet on the same input. Each output pair is compared against a bench model that walks the result bit by bit from the requirement rules. The bench model shares no staging with the design.

// File: rtl/opc_pkg.sv
package opc_pkg;
  localparam int DW = 64;
  localparam int HW = DW / 2;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_op_e;

  typedef enum logic [1:0] {
    FLD_B = 2'd0,
    FLD_H = 2'd1,
    FLD_W = 2'd2,
    FLD_X = 2'd3
  } field_e;

  // widen the selected low field of v to DW bits
  function automatic logic [DW-1:0] widen_field(input logic [DW-1:0] v,
                                                input logic [1:0] fld,
                                                input logic sgn);
    logic [DW-1:0] r;
    case (fld)
      FLD_B:   r = {{(DW-8){sgn & v[7]}}, v[7:0]};
      FLD_H:   r = {{(DW-16){sgn & v[15]}}, v[15:0]};
      FLD_W:   r = {{(DW-32){sgn & v[31]}}, v[31:0]};
      default: r = '0;
    endcase
    return r;
  endfunction

  // saturate a small shift amount to a limit
  function automatic logic [2:0] clamp_amt(input logic [2:0] a, input logic [2:0] lim);
    return (a > lim) ? lim : a;
  endfunction
endpackage

// File: rtl/opc_barrel.sv
module opc_barrel #(
  parameter int W = 64,
  localparam int AW = $clog2(W)
) (
  input  logic [W-1:0]      a_i,
  input  opc_pkg::shift_op_e op_i,
  input  logic [AW-1:0]     amt_i,
  output logic [W-1:0]      y_o,
  output logic              cout_o
);
  import opc_pkg::*;

  logic [W-1:0] a_rev;
  logic [W-1:0] stage_in;
  logic         fill_bit;
  logic         wrap;
  logic [W-1:0] st [0:AW];
  logic [W-1:0] st_rev;
  logic         last_out_w;

  // a left shift is a right shift on the bit-reversed operand
  always_comb begin
    for (int i = 0; i < W; i++) a_rev[i] = a_i[W-1-i];
  end

  assign stage_in = (op_i == SH_LSL) ? a_rev : a_i;
  assign fill_bit = (op_i == SH_ASR) & a_i[W-1];
  assign wrap     = (op_i == SH_ROR);
  assign st[0]    = stage_in;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign st[k+1] = !amt_i[k] ? st[k] :
                     wrap ? {st[k][SH-1:0], st[k][W-1:SH]} :
                            {{SH{fill_bit}}, st[k][W-1:SH]};
  end

  always_comb begin
    for (int i = 0; i < W; i++) st_rev[i] = st[AW][W-1-i];
  end

  // last bit to leave the bottom of the right-shifting stage input
  assign last_out_w = (amt_i != '0) & stage_in[amt_i - 1'b1];

  assign y_o    = (op_i == SH_LSL) ? st_rev : st[AW];
  assign cout_o = last_out_w;

  always_comb begin
    if (amt_i == '0)
      a_r7_zero_amount: assert (y_o == a_i && !cout_o)
        else $error("zero amount must pass operand");
    if (op_i == SH_ROR && amt_i != '0)
      a_r6_ror_carry: assert (cout_o == y_o[W-1])
        else $error("rotate carry must match result top bit");
    if (op_i == SH_ASR)
      a_r3_sign_kept: assert (y_o[W-1] == a_i[W-1])
        else $error("arithmetic shift lost sign");
    if (op_i == SH_LSL && amt_i != '0)
      a_r1_low_zero: assert (!y_o[0])
        else $error("left shift must zero-fill bit 0");
    if (op_i == SH_LSR && amt_i != '0)
      a_r2_top_zero: assert (!y_o[W-1])
        else $error("logical right shift must zero-fill top");
  end
endmodule

// File: rtl/opc_extend.sv
module opc_extend #(
  parameter int W     = opc_pkg::DW,
  parameter int SHMAX = 4,
  localparam int HALF = W / 2
) (
  input  logic [W-1:0] a_i,
  input  logic [2:0]   kind_i,
  input  logic [2:0]   amt_i,
  input  logic         wide_i,
  output logic [W-1:0] y_o
);
  import opc_pkg::*;

  logic         valid_w;
  logic [W-1:0] widened_w;
  logic [2:0]   sh_w;
  logic [W-1:0] shifted_w;

  assign valid_w   = (kind_i[1:0] != FLD_X) && (wide_i || kind_i[1:0] != FLD_W);
  assign widened_w = widen_field(a_i, kind_i[1:0], kind_i[2]);
  assign sh_w      = clamp_amt(amt_i, 3'(SHMAX));
  assign shifted_w = widened_w << sh_w;

  assign y_o = !valid_w ? '0 :
               wide_i   ? shifted_w : {{HALF{1'b0}}, shifted_w[HALF-1:0]};

  always_comb begin
    if (!valid_w)
      a_r12_invalid_zero: assert (y_o == '0)
        else $error("invalid extend must give zero");
    a_r10_low_bits_clear: assert ((y_o & ((W'(1) << sh_w) - W'(1))) == '0)
      else $error("post-extend shift left nonzero low bits");
  end
endmodule

// File: rtl/opc_operand_cond.sv
module opc_operand_cond (
  input  logic [63:0] opnd_i,
  input  logic        mode_i,
  input  logic [2:0]  sel_i,
  input  logic [5:0]  amt_i,
  input  logic        wide_i,
  output logic [63:0] res_o,
  output logic        cout_o
);
  import opc_pkg::*;

  localparam int AW64 = $clog2(DW);
  localparam int AW32 = $clog2(HW);

  shift_op_e   op_w;
  logic [DW-1:0] full_y;
  logic          full_c;
  logic [HW-1:0] half_y;
  logic          half_c;
  logic [DW-1:0] ext_y;
  logic [DW-1:0] shift_res_w;
  logic          shift_c_w;

  assign op_w = shift_op_e'(sel_i[1:0]);

  opc_barrel #(.W(DW)) u_full (
    .a_i(opnd_i), .op_i(op_w), .amt_i(amt_i[AW64-1:0]),
    .y_o(full_y), .cout_o(full_c)
  );

  opc_barrel #(.W(HW)) u_half (
    .a_i(opnd_i[HW-1:0]), .op_i(op_w), .amt_i(amt_i[AW32-1:0]),
    .y_o(half_y), .cout_o(half_c)
  );

  opc_extend #(.W(DW), .SHMAX(4)) u_ext (
    .a_i(opnd_i), .kind_i(sel_i), .amt_i(amt_i[2:0]), .wide_i(wide_i),
    .y_o(ext_y)
  );

  assign shift_res_w = wide_i ? full_y : {{HW{1'b0}}, half_y};
  assign shift_c_w   = wide_i ? full_c : half_c;

  assign res_o  = mode_i ? ext_y : shift_res_w;
  assign cout_o = mode_i ? 1'b0 : shift_c_w;

  always_comb begin
    if (!wide_i)
      a_r11_upper_zero: assert (res_o[DW-1:HW] == '0)
        else $error("32-bit view must clear upper half");
    if (mode_i)
      a_r13_extend_no_carry: assert (!cout_o)
        else $error("extend mode must not carry");
    if (!mode_i && wide_i && amt_i == '0)
      a_r7_port_passthru: assert (res_o == opnd_i && !cout_o)
        else $error("zero amount must pass operand at ports");
  end
endmodule

// File: tb/test_opc_operand_cond.sv
module test_opc_operand_cond;
  logic        clk = 1'b0;
  logic [63:0] opnd;
  logic        mode;
  logic [2:0]  sel;
  logic [5:0]  amt;
  logic        wide;
  logic [63:0] res;
  logic        cout;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  opc_operand_cond i_opc_operand_cond (
    .opnd_i(opnd), .mode_i(mode), .sel_i(sel), .amt_i(amt), .wide_i(wide),
    .res_o(res), .cout_o(cout)
  );

  // bench model: walks each result bit from the requirement rules
  function automatic logic [64:0] model(input logic [63:0] a, input logic m,
                                        input logic [2:0] s, input logic [5:0] n6,
                                        input logic w);
    int wd = w ? 64 : 32;
    int n  = w ? int'(n6) : int'(n6 % 32);
    logic [63:0] r = '0;
    logic c = 1'b0;
    if (!m) begin
      for (int i = 0; i < wd; i++) begin
        case (s[1:0])
          2'd0: r[i] = (i - n >= 0) ? a[i-n] : 1'b0;
          2'd1: r[i] = (i + n < wd) ? a[i+n] : 1'b0;
          2'd2: r[i] = (i + n < wd) ? a[i+n] : a[wd-1];
          default: r[i] = a[(i + n) % wd];
        endcase
      end
      if (n != 0) c = (s[1:0] == 2'd0) ? a[wd-n] : a[n-1];
    end else begin
      int sz = int'(s[1:0]);
      bit ok = (sz != 3) && (w || sz != 2);
      int bits = 8 << sz;
      int sh = (n6[2:0] > 3'd4) ? 4 : int'(n6[2:0]);
      logic [63:0] v = '0;
      if (ok) begin
        for (int i = 0; i < 64; i++)
          v[i] = (i < bits) ? a[i] : (s[2] & a[bits-1]);
        v = v << sh;
        if (!w) v[63:32] = '0;
        r = v;
      end
    end
    return {c, r};
  endfunction

  function automatic string tag_of(input logic m, input logic [2:0] s,
                                   input logic [5:0] n6, input logic w);
    if (!m) begin
      if ((w ? n6 : n6 % 32) == 0) return "R7";
      if (!w) return "R11";
      case (s[1:0])
        2'd0: return "R1";
        2'd1: return "R2";
        2'd2: return "R3";
        default: return "R4";
      endcase
    end
    if (s[1:0] == 2'd3 || (!w && s[1:0] == 2'd2)) return "R12";
    if (n6[2:0] != 3'd0) return "R10";
    return s[2] ? "R9" : "R8";
  endfunction

  task automatic apply_check(input logic [63:0] a, input logic m, input logic [2:0] s,
                             input logic [5:0] n6, input logic w, input string tag);
    logic [64:0] exp;
    @(posedge clk);
    opnd = a; mode = m; sel = s; amt = n6; wide = w;
    @(negedge clk);
    exp = model(a, m, s, n6, w);
    checks++;
    if (res !== exp[63:0]) begin
      fails++;
      $display("FAIL %s res: actual=%h expected=%h (m=%0d s=%0d n=%0d w=%0d)",
               tag, res, exp[63:0], m, s, n6, w);
    end
    checks++;
    if (cout !== exp[64]) begin
      fails++;
      $display("FAIL %s cout: actual=%0b expected=%0b (m=%0d s=%0d n=%0d w=%0d)",
               m ? "R13" : (s[1:0] == 2'd3 ? "R6" : "R5"), cout, exp[64], m, s, n6, w);
    end
  endtask

  initial begin
    opnd = '0; mode = 0; sel = '0; amt = '0; wide = 1;
    @(negedge clk);
    checks++;
    if (res !== '0 || cout !== 1'b0) begin
      fails++;
      $display("FAIL R7 idle: actual=%h/%0b expected=0/0", res, cout);
    end
    void'($urandom(32'h5eed));
    // directed corners
    apply_check(64'h8000_0000_0000_0001, 0, 3'd0, 6'd1,  1, "R1");
    apply_check(64'h8000_0000_0000_0001, 0, 3'd0, 6'd63, 1, "R5");
    apply_check(64'h8000_0000_0000_0001, 0, 3'd1, 6'd63, 1, "R2");
    apply_check(64'h8000_0000_0000_0000, 0, 3'd2, 6'd63, 1, "R3");
    apply_check(64'h0000_0000_0000_0003, 0, 3'd3, 6'd1,  1, "R4");
    apply_check(64'h0000_0000_0000_0002, 0, 3'd3, 6'd1,  1, "R6");
    apply_check(64'hdead_beef_1234_5678, 0, 3'd2, 6'd0,  1, "R7");
    apply_check(64'hffff_ffff_8000_0001, 0, 3'd2, 6'd33, 0, "R11");
    apply_check(64'hffff_ffff_8000_0001, 0, 3'd0, 6'd32, 0, "R11");
    apply_check(64'h1234_5678_9abc_de80, 1, 3'd0, 6'd0,  1, "R8");
    apply_check(64'h1234_5678_9abc_de80, 1, 3'd4, 6'd0,  1, "R9");
    apply_check(64'h1234_5678_8abc_de80, 1, 3'd6, 6'd0,  1, "R9");
    apply_check(64'h1234_5678_9abc_8e80, 1, 3'd5, 6'd7,  1, "R10");
    apply_check(64'h1234_5678_9abc_8e80, 1, 3'd5, 6'd44, 0, "R10");
    apply_check(64'h1234_5678_9abc_de80, 1, 3'd2, 6'd1,  0, "R12");
    apply_check(64'h1234_5678_9abc_de80, 1, 3'd7, 6'd1,  1, "R12");
    // random mix
    for (int t = 0; t < 3000; t++) begin
      logic [63:0] a = {$urandom, $urandom};
      logic m = 1'($urandom);
      logic [2:0] s = 3'($urandom);
      logic [5:0] n = 6'($urandom);
      logic w = ($urandom % 3) != 0;
      if ((t % 17) == 0) n = 6'd0;
      if ((t % 13) == 0) a = 64'h1 << ($urandom % 64);
      apply_check(a, m, s, n, w, tag_of(m, s, n, w));
    end
    done = 1;
  end

  always @(posedge clk) begin
    cycles++;
    if (done || cycles > 100000) begin
      if (!done) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule